// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block decides which interrupt a small processor core takes next. It has sixteen request slots. Slot 15 has the highest priority and slot 0 the lowest. Each slot keeps a request flag, which a peripheral event pulse sets, and a per-slot enable. One global enable gates every slot except those marked non-maskable. The controller never breaks into an instruction. It waits for the core to report an instruction boundary. At that boundary it takes the highest-numbered slot that is pending, drives that slot number as a vector index and pulses an acknowledge for one cycle.

Taking a request has side effects on the status state. The global enable is cleared, so no second maskable request can nest. The low-power state is cleared, so the core wakes. Both values are first copied into a one-level save register, and a return-from-interrupt strobe restores them. A slot that serves a single source has its flag cleared by the acceptance. A slot shared by several sources keeps its flag until software clears it, because software must find out which source raised it. Pushing state onto a stack and loading the program counter are left to the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all flags, all enables, the global enable, the low-power state, the acknowledge and the vector index. The vector index reads 0 after reset.
- R2: No acknowledge is issued in a cycle unless the instruction-boundary input was high at the clock edge that produced it. Pending requests wait for a boundary.
- R3: When several slots are pending at a boundary, the acknowledged vector index is the highest pending slot number.
- R4: Acceptance clears the flag of the accepted slot when that slot is single-source (every slot except 5 and 8 by default). Other flags are unchanged.
- R5: Acceptance leaves the flag of a multi-source slot (slots 5 and 8 by default) set. The flag-clear input then clears it.
- R6: Acceptance clears the global enable. While the global enable is 0, a boundary with only maskable requests pending gives no acknowledge.
- R7: The return strobe restores the global enable and the low-power state to the values they held when the last request was accepted.
- R8: A non-maskable slot (slot 14 by default) is accepted while the global enable is 0.
- R9: A slot whose flag is set but whose enable bit is 0 is never acknowledged, and its flag stays set.
- R10: The acknowledge is high for exactly one cycle. A boundary sampled while the acknowledge is high is ignored, even if a request is still pending.
- R11: Acceptance clears the low-power state that the sleep request input set.
- R12: A peripheral set pulse on a slot wins over a clear of that slot's flag in the same cycle, whether the clear comes from the flag-clear input or from acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqSet | input | 16 | Per-slot peripheral event pulse that sets the flag |
| flagClr | input | 16 | Per-slot software clear of the flag |
| enLoad | input | 1 | Load the per-slot enable register from enValue |
| enValue | input | 16 | New per-slot enable bits |
| gieSet | input | 1 | Software sets the global enable |
| gieClr | input | 1 | Software clears the global enable |
| sleepReq | input | 1 | Enter the low-power state |
| instrDone | input | 1 | Instruction boundary reported by the core |
| retInt | input | 1 | Return-from-interrupt strobe |
| ackPulse | output | 1 | One-cycle acknowledge of an accepted request |
| vecIdx | output | 4 | Slot number of the accepted request |
| flagsOut | output | 16 | Current request flags |
| gieOut | output | 1 | Current global enable |
| lowPowerOut | output | 1 | Current low-power state |

## Verification
The assertions assume the core does not assert the return strobe in the same cycle as a boundary that leads to acceptance. They also assume a new acceptance never happens while an earlier one's saved status is still needed by a maskable handler; only a non-maskable slot may overwrite it. The directed stimulus keeps return strobes and boundaries in separate cycles. The only intentional back-to-back acceptance is the held-boundary test on the non-maskable slot. That test checks that a set pulse landing in the acceptance cycle keeps the flag alive and that the one-cycle blocking window is honoured.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_SLOTS_P = 16;
  localparam int IDX_W_P = $clog2(NUM_SLOTS_P);

  // strobes from control to datapath
  typedef struct packed {
    logic               accept;
    logic [IDX_W_P-1:0] idx;
  } ctrlStb_t;
endpackage

// File: rtl/prio_irq_dpath.sv
module prio_irq_dpath
  import prio_irq_pkg::*;
#(
  parameter int NUM_SLOTS = NUM_SLOTS_P,
  parameter logic [NUM_SLOTS-1:0] MULTI_MASK = 16'h0120,
  parameter logic [NUM_SLOTS-1:0] NMI_MASK   = 16'h4000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] irqSet,
  input  logic [NUM_SLOTS-1:0] flagClr,
  input  logic                 enLoad,
  input  logic [NUM_SLOTS-1:0] enValue,
  input  logic                 gieSet,
  input  logic                 gieClr,
  input  logic                 sleepReq,
  input  logic                 retInt,
  input  ctrlStb_t             stb,
  output logic [NUM_SLOTS-1:0] pendVec,
  output logic [NUM_SLOTS-1:0] flagQ,
  output logic                 gieQ,
  output logic                 sleepQ
);
  logic [NUM_SLOTS-1:0] enQ;
  logic [NUM_SLOTS-1:0] autoClr;
  logic                 savedGie;
  logic                 savedSleep;

  // per-slot flag storage; a set pulse wins over any clear (R12)
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign autoClr[i] = stb.accept && (stb.idx == i) && !MULTI_MASK[i];
    always_ff @(posedge clk) begin
      if (rst) flagQ[i] <= 1'b0;
      else     flagQ[i] <= (flagQ[i] & ~flagClr[i] & ~autoClr[i]) | irqSet[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         enQ <= '0;
    else if (enLoad) enQ <= enValue;
  end

  // maskable slots also need the global enable
  assign pendVec = flagQ & enQ & (gieQ ? {NUM_SLOTS{1'b1}} : NMI_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      gieQ <= 1'b0;
      sleepQ <= 1'b0;
      savedGie <= 1'b0;
      savedSleep <= 1'b0;
    end else if (stb.accept) begin
      savedGie <= gieQ;
      savedSleep <= sleepQ;
      gieQ <= 1'b0;
      sleepQ <= 1'b0;
    end else if (retInt) begin
      gieQ <= savedGie;
      sleepQ <= savedSleep;
    end else begin
      if (gieClr)      gieQ <= 1'b0;
      else if (gieSet) gieQ <= 1'b1;
      if (sleepReq)    sleepQ <= 1'b1;
    end
  end

  assert_gie_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    stb.accept |=> !gieQ && !sleepQ);

  assert_return_restores_R7: assert property (@(posedge clk) disable iff (rst)
    (retInt && !stb.accept) |=> (gieQ == $past(savedGie)) && (sleepQ == $past(savedSleep)));

  assert_single_autoclear_R4: assert property (@(posedge clk) disable iff (rst)
    (stb.accept && !MULTI_MASK[stb.idx] && !irqSet[stb.idx]) |=> !flagQ[$past(stb.idx)]);

  assert_multi_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (stb.accept && MULTI_MASK[stb.idx] && !flagClr[stb.idx]) |=> flagQ[$past(stb.idx)]);
endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SLOTS = NUM_SLOTS_P,
  parameter logic [NUM_SLOTS-1:0] NMI_MASK = 16'h4000,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instrDone,
  input  logic [NUM_SLOTS-1:0] pendVec,
  input  logic                 gieIn,
  output ctrlStb_t             stb,
  output logic                 ackPulse,
  output logic [IDX_W-1:0]     vecIdx
);
  logic [IDX_W-1:0] selIdx;
  logic             anyPend;

  // ascending scan: last hit is the highest slot
  always_comb begin
    selIdx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (pendVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign anyPend = |pendVec;
  assign stb.accept = instrDone && anyPend && !ackPulse;
  assign stb.idx = selIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ackPulse <= 1'b0;
      vecIdx <= '0;
    end else begin
      ackPulse <= stb.accept;
      if (stb.accept) vecIdx <= selIdx;
    end
  end

  assert_boundary_only_R2: assert property (@(posedge clk) disable iff (rst)
    ackPulse |-> $past(instrDone));

  assert_highest_pick_R3: assert property (@(posedge clk) disable iff (rst)
    stb.accept |-> ((pendVec >> selIdx) == NUM_SLOTS'(1)));

  assert_one_cycle_ack_R10: assert property (@(posedge clk) disable iff (rst)
    ackPulse |=> !ackPulse);

  assert_nmi_only_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (stb.accept && !gieIn) |-> NMI_MASK[selIdx]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SLOTS = NUM_SLOTS_P,
  parameter logic [NUM_SLOTS-1:0] MULTI_MASK = 16'h0120,
  parameter logic [NUM_SLOTS-1:0] NMI_MASK   = 16'h4000,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] irqSet,
  input  logic [NUM_SLOTS-1:0] flagClr,
  input  logic                 enLoad,
  input  logic [NUM_SLOTS-1:0] enValue,
  input  logic                 gieSet,
  input  logic                 gieClr,
  input  logic                 sleepReq,
  input  logic                 instrDone,
  input  logic                 retInt,
  output logic                 ackPulse,
  output logic [IDX_W-1:0]     vecIdx,
  output logic [NUM_SLOTS-1:0] flagsOut,
  output logic                 gieOut,
  output logic                 lowPowerOut
);
  ctrlStb_t             stb;
  logic [NUM_SLOTS-1:0] pendVec;

  prio_irq_dpath #(
    .NUM_SLOTS(NUM_SLOTS), .MULTI_MASK(MULTI_MASK), .NMI_MASK(NMI_MASK)
  ) dpath_i (
    .clk(clk), .rst(rst), .irqSet(irqSet), .flagClr(flagClr),
    .enLoad(enLoad), .enValue(enValue), .gieSet(gieSet), .gieClr(gieClr),
    .sleepReq(sleepReq), .retInt(retInt), .stb(stb), .pendVec(pendVec),
    .flagQ(flagsOut), .gieQ(gieOut), .sleepQ(lowPowerOut)
  );

  prio_irq_ctl #(
    .NUM_SLOTS(NUM_SLOTS), .NMI_MASK(NMI_MASK)
  ) ctl_i (
    .clk(clk), .rst(rst), .instrDone(instrDone), .pendVec(pendVec),
    .gieIn(gieOut), .stb(stb), .ackPulse(ackPulse), .vecIdx(vecIdx)
  );
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] irqSet = '0, flagClr = '0, enValue = '0;
  logic enLoad = 0, gieSet = 0, gieClr = 0, sleepReq = 0, instrDone = 0, retInt = 0;
  logic ackPulse, gieOut, lowPowerOut;
  logic [3:0] vecIdx;
  logic [15:0] flagsOut;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .irqSet(irqSet), .flagClr(flagClr), .enLoad(enLoad),
    .enValue(enValue), .gieSet(gieSet), .gieClr(gieClr), .sleepReq(sleepReq),
    .instrDone(instrDone), .retInt(retInt), .ackPulse(ackPulse), .vecIdx(vecIdx),
    .flagsOut(flagsOut), .gieOut(gieOut), .lowPowerOut(lowPowerOut)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setFlags(logic [15:0] m);
    irqSet = m; tick(); irqSet = '0;
  endtask

  task automatic boundary();
    instrDone = 1; tick(); instrDone = 0;
  endtask

  task automatic doReturn();
    retInt = 1; tick(); retInt = 0;
  endtask

  task automatic t_reset();
    check("R1 ack", ackPulse, 0);
    check("R1 vec", vecIdx, 0);
    check("R1 flags", flagsOut, 0);
    check("R1 gie", gieOut, 0);
    check("R1 lowpower", lowPowerOut, 0);
  endtask

  task automatic t_noBoundary();
    enLoad = 1; enValue = 16'hFFFF; gieSet = 1; tick();
    enLoad = 0; gieSet = 0;
    setFlags(16'h0008);
    for (int k = 0; k < 4; k++) begin
      check("R2 no ack without boundary", ackPulse, 0);
      tick();
    end
    check("R2 flag waiting", flagsOut, 16'h0008);
  endtask

  task automatic t_priority();
    setFlags(16'h1200);
    boundary();
    check("R3 ack", ackPulse, 1);
    check("R3 highest vector", vecIdx, 12);
    check("R4 single flag cleared", flagsOut, 16'h0208);
    check("R6 gie cleared", gieOut, 0);
    tick();
    check("R10 ack dropped", ackPulse, 0);
  endtask

  task automatic t_nest();
    boundary();
    check("R6 no nesting", ackPulse, 0);
    check("R6 flags kept", flagsOut, 16'h0208);
  endtask

  task automatic t_return();
    doReturn();
    check("R7 gie restored", gieOut, 1);
    boundary();
    check("R3 next vector", vecIdx, 9);
    check("R4 flag 9 cleared", flagsOut, 16'h0008);
    doReturn();
    boundary();
    check("R3 lowest vector", vecIdx, 3);
    check("R4 all clear", flagsOut, 0);
    doReturn();
    check("R7 gie restored again", gieOut, 1);
  endtask

  task automatic t_multi();
    setFlags(16'h0100);
    boundary();
    check("R5 ack", ackPulse, 1);
    check("R5 vector", vecIdx, 8);
    check("R5 multi flag kept", flagsOut, 16'h0100);
    flagClr = 16'h0100; tick(); flagClr = '0;
    check("R5 software clear", flagsOut, 0);
    doReturn();
  endtask

  task automatic t_mask();
    enLoad = 1; enValue = 16'hFFDF; tick(); enLoad = 0;
    setFlags(16'h0020);
    boundary();
    check("R9 disabled slot not acked", ackPulse, 0);
    check("R9 flag stays", flagsOut, 16'h0020);
    flagClr = 16'h0020; tick(); flagClr = '0;
    enLoad = 1; enValue = 16'hFFFF; tick(); enLoad = 0;
  endtask

  task automatic t_setWins();
    setFlags(16'h0002);
    irqSet = 16'h0002; flagClr = 16'h0002; tick();
    irqSet = '0; flagClr = '0;
    check("R12 set beats clear", flagsOut, 16'h0002);
    flagClr = 16'h0002; tick(); flagClr = '0;
    check("R12 clear alone", flagsOut, 0);
  endtask

  task automatic t_nmi();
    gieClr = 1; tick(); gieClr = 0;
    check("R8 gie off", gieOut, 0);
    setFlags(16'h4000);
    boundary();
    check("R8 nmi acked", ackPulse, 1);
    check("R8 nmi vector", vecIdx, 14);
    check("R8 nmi flag cleared", flagsOut, 0);
    doReturn();
    check("R7 gie restored to 0", gieOut, 0);
  endtask

  task automatic t_sleep();
    gieSet = 1; sleepReq = 1; tick(); gieSet = 0; sleepReq = 0;
    check("R11 sleeping", lowPowerOut, 1);
    setFlags(16'h0004);
    boundary();
    check("R11 ack", ackPulse, 1);
    check("R11 woken", lowPowerOut, 0);
    doReturn();
    check("R7 sleep restored", lowPowerOut, 1);
    check("R7 gie restored", gieOut, 1);
  endtask

  task automatic t_pulse();
    gieClr = 1; tick(); gieClr = 0;
    setFlags(16'h4000);
    irqSet = 16'h4000; instrDone = 1; tick(); irqSet = '0;
    check("R10 first ack", ackPulse, 1);
    check("R12 set beats autoclear", flagsOut, 16'h4000);
    tick();
    check("R10 blocked cycle", ackPulse, 0);
    tick();
    instrDone = 0;
    check("R10 second ack", ackPulse, 1);
    check("R10 vector", vecIdx, 14);
    check("R4 nmi cleared", flagsOut, 0);
    tick();
    check("R10 ack low", ackPulse, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    rst = 0;
    t_reset();
    t_noBoundary();
    t_priority();
    t_nest();
    t_return();
    t_multi();
    t_mask();
    t_setWins();
    t_nmi();
    t_sleep();
    t_pulse();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule